// File: doc/BRIEF.md
# Time-of-Day Keeper

This block keeps the time of day. A divider counts cycles of the 27 MHz reference clock and makes a one-cycle tick once per second. The tick drives a chain of three counters: seconds, minutes and hours. Each counter passes a carry to the next one when it wraps. Three active-low push buttons act on the chain:

- a round-off button clears the seconds and, from the half-minute on, rounds up into the minutes;
- a minute-set button steps the minutes;
- an hour-set button steps the hours.

Every input is sampled on the reference clock. Each button passes through a two-flop synchronizer and a falling-edge detector, so one press makes exactly one single-cycle pulse. All counter updates happen in one synchronous cascade, with no asynchronous paths. The three counter values leave the block as plain binary buses for a display stage. They are level outputs that change only on the clock edge, and they carry no valid/ready handshake, because a display reads them continuously and can never stall them.

Top module: `tod_keeper`

## Requirements
- R1: While `rst` is high at a rising clock edge, the divider, seconds, minutes and hours all go to 0, and the button synchronizers are loaded with the released level (1).
- R2: Seconds advance by one every `TICK_DIV` reference cycles (default 27,000,000). With `rst` released, the first advance happens on the `TICK_DIV`-th rising edge.
- R3: Seconds count 0 to 59. On a tick at 59 they return to 0 and carry one step into the minutes.
- R4: A round-off press while seconds are 30 or more sets the seconds to 0 and steps the minutes by one. This step is a real carry: at minute 59 it also steps the hours. Round-off takes priority over a tick that arrives in the same cycle.
- R5: A round-off press while seconds are 29 or less sets the seconds to 0 and leaves the minutes unchanged.
- R6: Buttons are active low (0 means pressed). A button edge from 1 to 0 changes the counter after the third rising edge that follows it. Holding the button down gives exactly one step.
- R7: Each minute-set press adds one to the minutes. When a minute-set press takes the minutes from 59 to 0, the hours do not change.
- R8: Minutes count 0 to 59. When a seconds carry (from R3 or R4) wraps them from 59 to 0, the hours step by one.
- R9: Each hour-set press adds one to the hours. Hours count 0 to 23 and wrap to 0, whether they are stepped by a press or by a minute carry.
- R10: When a seconds carry and a minute-set press fall in the same cycle, the minutes advance by two, modulo 60. The hours step only if the minutes were 59 before that cycle.
- R11: When a minute carry and an hour-set press fall in the same cycle, the hours advance by two, modulo 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| round_n | input | 1 | Round-off button, active low |
| min_set_n | input | 1 | Minute-set button, active low |
| hr_set_n | input | 1 | Hour-set button, active low |
| seconds | output | 6 | Seconds value, 0 to 59 |
| minutes | output | 6 | Minutes value, 0 to 59 |
| hours | output | 5 | Hours value, 0 to 23 |

## Verification
The bench starts with a free-running count, which confirms the tick spacing. It then sends short presses and one long hold, which tells a proper edge detector apart from a level-driven counter. Round-off presses at seconds 10, 29, 30 and 35 locate the rounding threshold exactly. Further presses are timed to land on the same cycle as a tick, or as a minute carry. These separate an adder that sums both sources from one that lets a single source win, and they show whether manual wraps leak into the hours. A 23:59:59 rollover closes the chain.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int SEC_MOD      = 60;
  localparam int MIN_MOD      = 60;
  localparam int HR_MOD       = 24;
  localparam int SEC_W        = $clog2(SEC_MOD);
  localparam int MIN_W        = $clog2(MIN_MOD);
  localparam int HR_W         = $clog2(HR_MOD);
  localparam int SEC_ROUND_AT = SEC_MOD / 2;
  localparam int NUM_BTN      = 3;
  localparam int BTN_ROUND    = 0;
  localparam int BTN_MIN      = 1;
  localparam int BTN_HR       = 2;
endpackage

// File: rtl/tod_tick_gen.sv
`timescale 1ns/1ps
module tod_tick_gen #(
  parameter int DIV = 27_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((DIV == 1) || !tick)); // R2
endmodule

// File: rtl/tod_press.sv
`timescale 1ns/1ps
module tod_press #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n,
  output logic press
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], btn_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // falling edge of the synchronized, active-low level
  assign press = prev_q & ~sync_q[STAGES-1];

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    press |=> !press); // R6
endmodule

// File: rtl/tod_sec_ctr.sv
`timescale 1ns/1ps
module tod_sec_ctr
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             round,
  output logic [SEC_W-1:0] sec,
  output logic             carry
);
  localparam logic [SEC_W-1:0] TOP  = SEC_W'(SEC_MOD - 1);
  localparam logic [SEC_W-1:0] HALF = SEC_W'(SEC_ROUND_AT);

  always_comb begin
    carry = 1'b0;
    if (round)     carry = (sec >= HALF);
    else if (tick) carry = (sec == TOP);
  end

  always_ff @(posedge clk) begin
    if (rst)        sec <= '0;
    else if (round) sec <= '0;
    else if (tick)  sec <= (sec == TOP) ? '0 : sec + SEC_W'(1);
  end

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    sec <= TOP); // R3
  AST_ROUND_ZERO: assert property (@(posedge clk) disable iff (rst)
    round |=> (sec == '0)); // R5
endmodule

// File: rtl/tod_mod_ctr.sv
`timescale 1ns/1ps
module tod_mod_ctr #(
  parameter int MOD = 60,
  parameter int W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_auto,
  input  logic         step_man,
  output logic [W-1:0] value,
  output logic         carry
);
  localparam logic [W:0]   MODW = (W+1)'(MOD);
  localparam logic [W-1:0] TOP  = W'(MOD - 1);

  logic [W:0] sum;
  logic [W:0] nxt;

  // only the chained step may leave a carry; manual wraps stay local
  assign carry = step_auto && (value == TOP);

  always_comb begin
    sum = {1'b0, value} + {{W{1'b0}}, step_auto} + {{W{1'b0}}, step_man};
    nxt = (sum >= MODW) ? (sum - MODW) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= nxt[W-1:0];
  end

  AST_VAL_RANGE: assert property (@(posedge clk) disable iff (rst)
    {1'b0, value} < MODW); // R8
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(step_auto || step_man) |=> $stable(value)); // R7
endmodule

// File: rtl/tod_keeper.sv
`timescale 1ns/1ps
module tod_keeper
  import tod_pkg::*;
#(
  parameter int TICK_DIV    = 27_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             round_n,
  input  logic             min_set_n,
  input  logic             hr_set_n,
  output logic [SEC_W-1:0] seconds,
  output logic [MIN_W-1:0] minutes,
  output logic [HR_W-1:0]  hours
);
  logic               tick;
  logic [NUM_BTN-1:0] btn_n_v;
  logic [NUM_BTN-1:0] press_v;
  logic               sec_carry;
  logic               min_carry;
  logic               hr_carry;

  assign btn_n_v = {hr_set_n, min_set_n, round_n};

  tod_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  for (genvar gi = 0; gi < NUM_BTN; gi++) begin : g_btn
    tod_press #(.STAGES(SYNC_STAGES)) u_press (
      .clk  (clk),
      .rst  (rst),
      .btn_n(btn_n_v[gi]),
      .press(press_v[gi])
    );
  end

  tod_sec_ctr u_sec (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .round(press_v[BTN_ROUND]),
    .sec  (seconds),
    .carry(sec_carry)
  );

  tod_mod_ctr #(.MOD(MIN_MOD), .W(MIN_W)) u_min (
    .clk      (clk),
    .rst      (rst),
    .step_auto(sec_carry),
    .step_man (press_v[BTN_MIN]),
    .value    (minutes),
    .carry    (min_carry)
  );

  tod_mod_ctr #(.MOD(HR_MOD), .W(HR_W)) u_hr (
    .clk      (clk),
    .rst      (rst),
    .step_auto(min_carry),
    .step_man (press_v[BTN_HR]),
    .value    (hours),
    .carry    (hr_carry)
  );

  AST_HR_GUARDED: assert property (@(posedge clk) disable iff (rst)
    (!min_carry && !press_v[BTN_HR]) |=> $stable(hours)); // R7
  AST_ROUND_UP: assert property (@(posedge clk) disable iff (rst)
    (press_v[BTN_ROUND] && !press_v[BTN_MIN] && seconds >= SEC_W'(SEC_ROUND_AT)
     && minutes != MIN_W'(MIN_MOD - 1))
    |=> (minutes == $past(minutes) + MIN_W'(1))); // R4
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (hr_carry && !press_v[BTN_HR]) |=> (hours == '0)); // R9
endmodule

// File: tb/sim_tod_keeper.sv
`timescale 1ns/1ps
module sim_tod_keeper;
  localparam int DIV = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic round_n = 1'b1, min_n = 1'b1, hr_n = 1'b1;
  logic [5:0] seconds, minutes;
  logic [4:0] hours;

  always #4 clk = ~clk;

  tod_keeper #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .round_n(round_n), .min_set_n(min_n),
    .hr_set_n(hr_n), .seconds(seconds), .minutes(minutes), .hours(hours)
  );

  // reference model built from the requirements
  int md, ms, mm, mh;
  logic [2:0] b1, b2, bp;
  always @(posedge clk) begin
    logic [2:0] pr;
    logic tk, cs, cm;
    if (rst) begin
      md <= 0; ms <= 0; mm <= 0; mh <= 0;
      b1 <= '1; b2 <= '1; bp <= '1;
    end else begin
      pr = bp & ~b2;
      tk = (md == DIV - 1);
      cs = 1'b0;
      md <= tk ? 0 : md + 1;
      if (pr[0]) begin
        cs = (ms >= 30);
        ms <= 0;
      end else if (tk) begin
        cs = (ms == 59);
        ms <= (ms == 59) ? 0 : ms + 1;
      end
      cm = cs && (mm == 59);
      mm <= (mm + int'(cs) + int'(pr[1])) % 60;
      mh <= (mh + int'(cm) + int'(pr[2])) % 24;
      b1 <= {hr_n, min_n, round_n};
      b2 <= b1;
      bp <= b2;
    end
  end

  typedef struct {int h; int m; int s; string tag;} exp_t;
  exp_t q[$];
  int tests = 0, failed = 0;
  bit done = 1'b0;

  task automatic expect_hms(input int h, input int m, input int s, input string tag);
    exp_t e;
    e.h = h; e.m = m; e.s = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic expect_model(input string tag);
    expect_hms(mh, mm, ms, tag);
  endtask

  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      tests++;
      if (int'(hours) != e.h || int'(minutes) != e.m || int'(seconds) != e.s) begin
        failed++;
        $display("FAIL %s got %0d:%0d:%0d exp %0d:%0d:%0d", e.tag,
                 hours, minutes, seconds, e.h, e.m, e.s);
      end
    end
  end

  task automatic set_btn(input int b, input logic v);
    case (b)
      0: round_n = v;
      1: min_n = v;
      default: hr_n = v;
    endcase
  endtask

  task automatic press(input int b, input int hold);
    set_btn(b, 1'b0);
    repeat (hold) @(negedge clk);
    set_btn(b, 1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_at(input int s, input int d);
    while (!(ms == s && md == d)) @(negedge clk);
  endtask

  // press edge placed so the pulse lands in the tick cycle at second s
  task automatic press_on_tick(input int b, input int s);
    wait_at(s, DIV - 3);
    set_btn(b, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic release_all();
    round_n = 1'b1; min_n = 1'b1; hr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_min(input int t);
    while (mm != t) press(1, 4);
  endtask

  task automatic set_hr(input int t);
    while (mh != t) press(2, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_hms(0, 0, 0, "R1 reset");
    rst = 1'b0;
    repeat (3 * DIV - 1) @(negedge clk);
    expect_hms(0, 0, 2, "R2 before third tick");
    @(negedge clk);
    expect_hms(0, 0, 3, "R2 third tick");

    repeat (3) press(1, 4);
    expect_hms(0, 3, ms, "R7 three presses");
    min_n = 1'b0;
    @(negedge clk); @(negedge clk);
    expect_hms(0, 3, ms, "R6 no step before third edge");
    @(negedge clk);
    expect_hms(0, 4, ms, "R6 step at third edge");
    repeat (30) @(negedge clk);
    min_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_hms(0, 4, ms, "R6 long hold one step");

    wait_at(1, 0);
    set_min(59);
    press(1, 4);
    expect_hms(0, 0, ms, "R7 manual wrap keeps hours");
    set_hr(23);
    expect_hms(23, 0, ms, "R9 hour set");
    press(2, 4);
    expect_hms(0, 0, ms, "R9 hour set wrap");

    wait_at(1, 0);
    set_hr(23);
    set_min(59);
    wait_at(59, DIV - 1);
    expect_hms(23, 59, 59, "R3 before rollover");
    @(negedge clk);
    expect_hms(0, 0, 0, "R3/R8/R9 day rollover");

    wait_at(35, 5);
    press(0, 4);
    expect_hms(0, 1, 0, "R4 round up at 35");
    wait_at(30, 5);
    press(0, 4);
    expect_hms(0, 2, 0, "R4 round up at 30");
    wait_at(29, 5);
    press(0, 4);
    expect_hms(0, 2, 0, "R5 round down at 29");
    wait_at(10, 5);
    press(0, 4);
    expect_hms(0, 2, 0, "R5 round down at 10");
    press_on_tick(0, 45);
    expect_hms(0, 3, 0, "R4 round beats tick");
    release_all();

    wait_at(1, 0);
    set_min(59);
    press_on_tick(1, 59);
    expect_hms(1, 1, 0, "R10 carry plus press at 59");
    release_all();
    wait_at(1, 0);
    set_min(58);
    press_on_tick(1, 59);
    expect_hms(1, 0, 0, "R10 carry plus press at 58");
    release_all();

    wait_at(1, 0);
    set_hr(23);
    set_min(59);
    press_on_tick(2, 59);
    expect_hms(1, 0, 0, "R11 carry plus hour press wraps");
    release_all();
    wait_at(1, 0);
    set_min(59);
    press_on_tick(2, 59);
    expect_hms(3, 0, 0, "R11 carry plus hour press");
    release_all();

    repeat (2 * DIV + 7) @(negedge clk);
    expect_model("R2 model agreement");
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog expired, got %0d:%0d:%0d exp completion", hours, minutes, seconds);
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule